// File: doc/BRIEF.md
# Retriggerable Gate Generator with Trailing Pulse

This block opens a timing gate when a start trigger arrives and holds it open for a programmed number of clock ticks. A start that arrives while the gate is open restarts the count. In latch mode the programmed length is ignored, and the gate stays open until a stop arrives. A stop closes the gate at any time.

The visible gate is shaped before it leaves the block. An auxiliary OR input can force it high, and a blank input suppresses it completely. When the internally generated gate closes, the block emits a trailing pulse whose length is chosen by a 2-bit code from four fixed multiples of a base unit.

All inputs are synchronous to the clock. Both outputs are registered.

Top module: `gate_pulse_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `gate_o` and `pulse_o` are low.
- R2: A start, sampled at edge k, makes `gate_o` high from edge k+1 up to and including edge k+W, where W is `len_i`. A `len_i` of zero behaves as one tick.
- R3: A start while the gate is open reloads the count, so the gate closes W ticks after the most recent start.
- R4: With `hold_i` high, the gate stays open after a start until a stop is sampled, whatever the value of `len_i`.
- R5: A stop closes the gate at the next edge. A stop sampled in the same cycle as a start wins, and no gate opens.
- R6: `gate_o` is high in the cycle after `or_i` is high, provided `blank_i` is low in that same cycle. This holds even when no gate is open, and on its own it produces no trailing pulse.
- R7: `gate_o` is low in the cycle after `blank_i` is high. Blanking only part of the gate does not shorten the underlying count.
- R8: When the generated gate closes, `pulse_o` goes high in the cycle right after the last high cycle of `gate_o`. It stays high for a number of ticks set by `pw_sel_i`: 0 gives 10, 1 gives 30, 2 gives 100 and 3 gives 300.
- R9: If `blank_i` is high in the cycle in which the generated gate closes, no trailing pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Trigger that opens or restarts the gate |
| stop_i | input | 1 | Closes the gate; has priority over start |
| or_i | input | 1 | Auxiliary input ORed into the gate output |
| blank_i | input | 1 | Vetoes the gate output |
| hold_i | input | 1 | Latch mode: the gate is held until a stop |
| len_i | input | 24 | Gate length in ticks (0 is treated as 1) |
| pw_sel_i | input | 2 | Trailing pulse length code |
| gate_o | output | 1 | Shaped gate output |
| pulse_o | output | 1 | Trailing pulse output |

## Verification
The hardest situation to reach is a gate whose closing edge is visible only inside the block. This happens when blank hides the gate at the outputs, or when a stop ends a latched gate. Here the pulse must still appear, or be suppressed, according to the value of blank at that one closing cycle. The stimulus covers both cases. It blanks a window in the middle of a 20-tick gate, so the count and the pulse must survive. It then holds blank across a whole shot, so both outputs must stay low. A restart is issued a few ticks into a shot to show that the closing point moves.

// File: rtl/gate_pulse_pkg.sv
package gate_pulse_pkg;
  typedef enum logic [1:0] {PW_X1 = 2'd0, PW_X3 = 2'd1, PW_X10 = 2'd2, PW_X30 = 2'd3} pw_code_e;

  function automatic int unsigned pulse_ticks(input logic [1:0] code, input int unsigned unit);
    case (pw_code_e'(code))
      PW_X1:   return unit;
      PW_X3:   return 3 * unit;
      PW_X10:  return 10 * unit;
      default: return 30 * unit;
    endcase
  endfunction
endpackage

// File: rtl/gate_timer.sv
module gate_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             gate_q_o,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             gate_q;
  logic [CNT_W-1:0] load_val;
  logic             expire;

  always_comb begin
    load_val = (len_i == '0) ? '0 : len_i - 1'b1;
    expire   = gate_q && !hold_i && (cnt_q == '0);
    end_o    = gate_q && (stop_i || (expire && !start_i));
    gate_q_o = gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (stop_i) begin
      gate_q <= 1'b0;
    end else if (start_i) begin
      gate_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (gate_q && !hold_i) begin
      if (cnt_q == '0) gate_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    start_i && !stop_i |=> gate_q); // R2
  AST_EXPIRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    gate_q && !hold_i && cnt_q == '0 && !start_i |=> !gate_q); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    gate_q && hold_i && !stop_i |=> gate_q); // R4
  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !gate_q); // R5
endmodule

// File: rtl/trail_pulse.sv
module trail_pulse #(
  parameter int UNIT = 10,
  parameter int PC_W = $clog2(30 * UNIT + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_i,
  input  logic [1:0] sel_i,
  output logic       active_o
);
  import gate_pulse_pkg::*;
  localparam int MAX_LEN = 30 * UNIT;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] len_val;

  always_comb begin
    len_val  = PC_W'(pulse_ticks(sel_i, UNIT));
    active_o = (pc_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)              pc_q <= '0;
    else if (trig_i)      pc_q <= len_val;
    else if (pc_q != '0)  pc_q <= pc_q - 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pc_q <= PC_W'(MAX_LEN)); // R8
  AST_PULSE_FALLS: assert property (@(posedge clk) disable iff (rst)
    !trig_i && pc_q == PC_W'(1) |=> !active_o); // R8
endmodule

// File: rtl/gate_pulse_gen.sv
module gate_pulse_gen #(
  parameter int CNT_W   = 24,
  parameter int PW_UNIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             or_i,
  input  logic             blank_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [1:0]       pw_sel_i,
  output logic             gate_o,
  output logic             pulse_o
);
  localparam int PC_W = $clog2(30 * PW_UNIT + 1);

  logic gate_q;
  logic gate_end;
  logic pulse_act;
  logic trig;

  gate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .hold_i(hold_i), .len_i(len_i), .gate_q_o(gate_q), .end_o(gate_end)
  );

  always_comb trig = gate_end && !blank_i;

  trail_pulse #(.UNIT(PW_UNIT), .PC_W(PC_W)) u_pulse (
    .clk(clk), .rst(rst), .trig_i(trig), .sel_i(pw_sel_i), .active_o(pulse_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      gate_o  <= (gate_q || or_i) && !blank_i;
      pulse_o <= pulse_act;
    end
  end

  AST_BLANK_VETO: assert property (@(posedge clk) disable iff (rst)
    blank_i |=> !gate_o); // R7
  AST_OR_PASS: assert property (@(posedge clk) disable iff (rst)
    or_i && !blank_i |=> gate_o); // R6
  AST_BLANK_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    gate_end && blank_i && !pulse_act |=> !pulse_act); // R9
endmodule

// File: tb/sim_gate_pulse_gen.sv
module sim_gate_pulse_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, stop_i = 0, or_i = 0, blank_i = 0, hold_i = 0;
  logic [23:0] len_i = '0;
  logic [1:0]  pw_sel_i = '0;
  logic gate_o, pulse_o;

  int total = 0, bad = 0;
  int g_cnt, d_cnt, g_first, g_last, d_first;

  always #2.5 clk = ~clk;

  gate_pulse_gen u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .or_i(or_i),
    .blank_i(blank_i), .hold_i(hold_i), .len_i(len_i), .pw_sel_i(pw_sel_i),
    .gate_o(gate_o), .pulse_o(pulse_o)
  );

  // columns: length, width code, expected gate ticks, expected pulse ticks
  localparam int VEC [5][4] = '{
    '{5, 0, 5, 10}, '{1, 1, 1, 30}, '{0, 2, 1, 100}, '{20, 3, 20, 300}, '{7, 1, 7, 30}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a shot at the first negedge; samples follow, index 0 at the next negedge.
  task automatic shot(input int w, input int pw, input int hold, input int stop_at,
                      input int re_at, input int bl_from, input int bl_to, input int m);
    g_cnt = 0; d_cnt = 0; g_first = -1; g_last = -1; d_first = -1;
    @(negedge clk);
    len_i = w[23:0]; pw_sel_i = pw[1:0]; hold_i = hold[0];
    start_i = 1'b1;
    blank_i = (bl_from < 0 && bl_to >= 0);
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      if (gate_o) begin
        g_cnt++; if (g_first < 0) g_first = i; g_last = i;
      end
      if (pulse_o) begin
        d_cnt++; if (d_first < 0) d_first = i;
      end
      start_i = (i == re_at);
      stop_i  = (i == stop_at);
      blank_i = (i >= bl_from && i <= bl_to);
    end
    start_i = 0; stop_i = 0; blank_i = 0; hold_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", gate_o, 0);
    chk("R1 pulse in reset", pulse_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 gate after reset", gate_o, 0);
    chk("R1 pulse after reset", pulse_o, 0);

    foreach (VEC[v]) begin
      shot(VEC[v][0], VEC[v][1], 0, -1, -1, -1, -2, VEC[v][0] + VEC[v][3] + 10);
      chk("R2 gate length", g_cnt, VEC[v][2]);
      chk("R2 gate start", g_first, 1);
      chk("R8 pulse length", d_cnt, VEC[v][3]);
      chk("R8 pulse follows gate", d_first, g_last + 1);
    end

    // R3: a restart at the sample-2 edge with length 10 gives 13 open ticks
    shot(10, 0, 0, -1, 2, -1, -2, 40);
    chk("R3 restart length", g_cnt, 13);
    chk("R3 pulse after restart", d_cnt, 10);

    // R4: latch mode; stop driven after sample 40 closes the gate
    shot(3, 0, 1, 40, -1, -1, -2, 70);
    chk("R4 latched gate", g_cnt, 41);
    chk("R4 pulse after stop", d_first, g_last + 1);

    // R5: stop during a long gate
    shot(100, 0, 0, 4, -1, -1, -2, 30);
    chk("R5 stop shortens gate", g_cnt, 5);
    chk("R5 pulse after stop", d_cnt, 10);

    // R5: start and stop together, no gate
    @(negedge clk); start_i = 1; stop_i = 1; len_i = 5;
    @(negedge clk); start_i = 0; stop_i = 0;
    g_cnt = 0; d_cnt = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk); g_cnt += gate_o; d_cnt += pulse_o;
    end
    chk("R5 stop priority gate", g_cnt, 0);
    chk("R5 stop priority pulse", d_cnt, 0);

    // R6: OR input alone for 3 cycles
    @(negedge clk); or_i = 1;
    g_cnt = 0; d_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); g_cnt += gate_o; d_cnt += pulse_o;
      if (i == 2) or_i = 0;
    end
    chk("R6 OR gate ticks", g_cnt, 3);
    chk("R6 OR no pulse", d_cnt, 0);

    // R7: blank in the middle of a 20-tick gate
    shot(20, 0, 0, -1, -1, 2, 6, 45);
    chk("R7 blanked gate ticks", g_cnt, 15);
    chk("R7 pulse survives partial blank", d_cnt, 10);
    chk("R7 pulse still after count", d_first, 21);

    // R9: blank held across the whole shot, including the closing cycle
    shot(5, 1, 0, -1, -1, -1, 100, 50);
    chk("R9 gate fully blanked", g_cnt, 0);
    chk("R9 no pulse when blanked at end", d_cnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule